// File: doc/BRIEF.md
# Pixel Stream to AXI4-Stream Video Bridge

This block takes a serial pixel stream and presents it as an AXI4-Stream Video master. On the input side a producer delivers one pixel word per cycle with a valid flag and four control flags. The flags mark the first and last active pixel of a line, and the first and last active pixel of a frame. Blanking cycles carry valid low and are dropped. Each accepted pixel becomes one output beat. The frame-start flag travels as TUSER (one bit wide here). The line-end flag becomes TLAST, and so does the frame-end flag, because the last pixel of a frame is also the last pixel of a line.

Back-pressure works on both sides through valid/ready. On the output side, the downstream sink stalls beats with `m_axis_tready` in the usual AXI4-Stream way: a beat moves on a cycle where TVALID and TREADY are both high. On the input side, `pix_ready` is a registered function of how many pixels are stored. The producer may present one more pixel in the cycle after it sees `pix_ready` fall, and it must hold `pix_valid` low from the second such cycle on. The bridge keeps one output slot plus `SKID_DEPTH` spare entries, so that late pixel is never lost. If no back-pressure is needed, the sink ties `m_axis_tready` high and the bridge passes one pixel per cycle.

Top module: `pix2axis_bridge`

## Requirements
- R1: After reset, `m_axis_tvalid` is low, `pix_ready` is high and no pixel is stored.
- R2: Only cycles with `pix_valid` high create beats. Beats leave in arrival order with `m_axis_tdata` equal to the pixel word. Data and flags seen while `pix_valid` is low have no effect.
- R3: `m_axis_tuser` is high on a beat exactly when that pixel carried the frame-start flag.
- R4: `m_axis_tlast` is high on a beat exactly when that pixel carried the line-end flag or the frame-end flag.
- R5: While `m_axis_tvalid` is high and `m_axis_tready` is low, `m_axis_tvalid`, `m_axis_tdata`, `m_axis_tuser` and `m_axis_tlast` keep their values into the next cycle.
- R6: `pix_ready` is high exactly when fewer than `SKID_DEPTH` (default 2) pixels are held, counting the state at the start of the cycle. It does not react to `m_axis_tready` within the same cycle.
- R7: A pixel presented in the cycle right after `pix_ready` falls is accepted and delivered. A producer that follows the one-cycle rule never overflows the bridge.
- R8: `m_axis_tvalid` is high exactly when at least one pixel is held. A pixel accepted into an empty bridge is offered on the output in the next cycle.
- R9: With `m_axis_tready` held high and a pixel every cycle, the bridge accepts one pixel per cycle and `pix_ready` never drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel word and flags are meaningful this cycle |
| pix_data | input | DATA_W | Pixel word |
| pix_line_first | input | 1 | First active pixel of a line |
| pix_line_last | input | 1 | Last active pixel of a line |
| pix_frame_first | input | 1 | First active pixel of a frame |
| pix_frame_last | input | 1 | Last active pixel of a frame |
| pix_ready | output | 1 | Registered space indication to the producer |
| m_axis_tvalid | output | 1 | Output beat present |
| m_axis_tready | input | 1 | Sink accepts the beat |
| m_axis_tdata | output | DATA_W | Beat data |
| m_axis_tuser | output | 1 | Start-of-frame marker |
| m_axis_tlast | output | 1 | End-of-line marker |

## Verification
Two events can land in the same cycle: a late pixel written into the skid storage, and a stored beat leaving through the output. The bench provokes this by sweeping several `m_axis_tready` patterns (steady, alternating, long stall bursts, pseudo-random) against frames of one to four pixels per line and one to three lines, with and without blanking gaps. Its producer always uses the one-cycle grace after `pix_ready` falls. Every beat is compared with a pixel word computed from frame, row and column. Each cycle, `pix_ready` and `m_axis_tvalid` are compared with an occupancy count the bench keeps itself.

// File: rtl/pix2axis_pkg.sv
package pix2axis_pkg;

  // control flags that travel beside each pixel word
  typedef struct packed {
    logic line_first;
    logic line_last;
    logic frame_first;
    logic frame_last;
  } pix_ctl_t;

  // sideband bits packed above the data word in every stored beat
  localparam int unsigned SIDEBAND_W = 2;

endpackage

// File: rtl/pix2axis_map.sv
module pix2axis_map
  import pix2axis_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  localparam int unsigned BEAT_W = DATA_W + SIDEBAND_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  pix_ctl_t          in_ctl,
  output logic              push,
  output logic [BEAT_W-1:0] beat
);

  logic sof_bit;
  logic eol_bit;

  always_comb begin
    sof_bit = in_ctl.frame_first;
    // the frame's last pixel always closes a line
    eol_bit = in_ctl.line_last | in_ctl.frame_last;
    push    = in_valid;
    beat    = {sof_bit, eol_bit, in_data};
  end

  // R3
  sof_on_line_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ctl.frame_first |-> in_ctl.line_first);

  // R4
  eof_on_line_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ctl.frame_last |-> in_ctl.line_last);

endmodule

// File: rtl/pix2axis_skid_fifo.sv
module pix2axis_skid_fifo #(
  parameter int unsigned W     = 26,
  parameter int unsigned DEPTH = 3,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          nonempty,
  output logic [CW-1:0] count_next
);

  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam int unsigned   SLOTS    = 1 << PW;

  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] count;
  logic          full;
  logic          push_ok;
  logic          pop_ok;
  logic [W-1:0]  slot [SLOTS];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    full     = (count == FULL_CNT);
    nonempty = (count != '0);
    push_ok  = push && !full;
    pop_ok   = pop && nonempty;
    unique case ({push_ok, pop_ok})
      2'b10:   count_next = count + CW'(1);
      2'b01:   count_next = count - CW'(1);
      default: count_next = count;
    endcase
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < DEPTH) begin : g_store
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
        if (push_ok && (wr_ptr == PW'(g))) q <= wdata;
      end
      assign slot[g] = q;
    end else begin : g_pad
      assign slot[g] = '0;
    end
  end

  assign rdata = slot[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      count <= count_next;
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R8
  always_ff @(posedge clk) begin
    if (rst_n) count_bound_chk: assert (count <= FULL_CNT);
  end

endmodule

// File: rtl/pix2axis_ready_ctl.sv
module pix2axis_ready_ctl #(
  parameter int unsigned DEPTH = 3,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_next,
  input  logic          in_valid,
  output logic          in_ready
);

  // one entry is kept back for the pixel that arrives after ready falls
  localparam logic [CW-1:0] OPEN_LIMIT = CW'(DEPTH - 2);

  logic ready_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b1;
    else        ready_q <= (count_next <= OPEN_LIMIT);
  end

  assign in_ready = ready_q;

  // R7
  lag_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready && !$past(in_ready) |-> !in_valid);

endmodule

// File: rtl/pix2axis_bridge.sv
module pix2axis_bridge
  import pix2axis_pkg::*;
#(
  parameter int unsigned DATA_W     = 24,
  parameter int unsigned SKID_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [DATA_W-1:0] pix_data,
  input  logic              pix_line_first,
  input  logic              pix_line_last,
  input  logic              pix_frame_first,
  input  logic              pix_frame_last,
  output logic              pix_ready,
  output logic              m_axis_tvalid,
  input  logic              m_axis_tready,
  output logic [DATA_W-1:0] m_axis_tdata,
  output logic              m_axis_tuser,
  output logic              m_axis_tlast
);

  localparam int unsigned BEAT_W = DATA_W + SIDEBAND_W;
  localparam int unsigned DEPTH  = SKID_DEPTH + 1;
  localparam int unsigned CW     = $clog2(DEPTH + 1);

  pix_ctl_t          ctl;
  logic              push;
  logic [BEAT_W-1:0] beat_in;
  logic [BEAT_W-1:0] beat_out;
  logic              pop;
  logic [CW-1:0]     count_next;

  assign ctl = '{line_first:  pix_line_first,
                 line_last:   pix_line_last,
                 frame_first: pix_frame_first,
                 frame_last:  pix_frame_last};

  pix2axis_map #(.DATA_W(DATA_W)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (pix_valid),
    .in_data  (pix_data),
    .in_ctl   (ctl),
    .push     (push),
    .beat     (beat_in)
  );

  pix2axis_skid_fifo #(.W(BEAT_W), .DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .wdata      (beat_in),
    .pop        (pop),
    .rdata      (beat_out),
    .nonempty   (m_axis_tvalid),
    .count_next (count_next)
  );

  pix2axis_ready_ctl #(.DEPTH(DEPTH)) u_ready (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_next (count_next),
    .in_valid   (pix_valid),
    .in_ready   (pix_ready)
  );

  assign pop = m_axis_tvalid && m_axis_tready;
  assign {m_axis_tuser, m_axis_tlast, m_axis_tdata} = beat_out;

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_axis_tvalid && !m_axis_tready |=> m_axis_tvalid && $stable(m_axis_tdata)
      && $stable(m_axis_tuser) && $stable(m_axis_tlast));

endmodule

// File: tb/pix2axis_bridge_bench.sv
`timescale 1ns/1ps
module pix2axis_bridge_bench;

  localparam int DATA_W = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pix_valid = 1'b0;
  logic [DATA_W-1:0] pix_data = '0;
  logic              pix_line_first = 1'b0;
  logic              pix_line_last = 1'b0;
  logic              pix_frame_first = 1'b0;
  logic              pix_frame_last = 1'b0;
  logic              pix_ready;
  logic              m_axis_tvalid;
  logic              m_axis_tready = 1'b0;
  logic [DATA_W-1:0] m_axis_tdata;
  logic              m_axis_tuser;
  logic              m_axis_tlast;

  always #4 clk = ~clk;

  pix2axis_bridge #(.DATA_W(DATA_W), .SKID_DEPTH(2)) u_pix2axis_bridge (
    .clk(clk), .rst_n(rst_n),
    .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_line_first(pix_line_first), .pix_line_last(pix_line_last),
    .pix_frame_first(pix_frame_first), .pix_frame_last(pix_frame_last),
    .pix_ready(pix_ready),
    .m_axis_tvalid(m_axis_tvalid), .m_axis_tready(m_axis_tready),
    .m_axis_tdata(m_axis_tdata), .m_axis_tuser(m_axis_tuser),
    .m_axis_tlast(m_axis_tlast)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // expected beats: {tuser, tlast, data}
  logic [DATA_W+1:0] exp_q [1024];
  int  wr_n = 0;
  int  rd_n = 0;
  int  lag_n = 0;
  int  cyc = 0;
  int  mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic rdy_prev = 1'b1;
  logic hold_prev = 1'b0;
  logic [DATA_W+1:0] held;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic pick_tready();
    case (mode)
      0:       return 1'b1;
      1:       return cyc[0];
      2:       return (cyc % 5) < 2;
      default: return lfsr[0];
    endcase
  endfunction

  // one cycle: check the state left by the last edge, then drive the next one
  task automatic step(input bit want, input logic [DATA_W-1:0] d,
                      input logic [3:0] f, output bit sent);
    int occ;
    logic rdy_now;
    logic allowed;
    logic [DATA_W+1:0] got;
    @(negedge clk);
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    occ = wr_n - rd_n;
    // R8: tvalid tracks held pixels
    check(m_axis_tvalid === (occ > 0), "R8", 64'(m_axis_tvalid), 64'(occ > 0));
    // R6: ready from occupancy only
    check(pix_ready === (occ <= 1), "R6", 64'(pix_ready), 64'(occ <= 1));
    got = {m_axis_tuser, m_axis_tlast, m_axis_tdata};
    if (hold_prev) begin
      // R5: stalled beat unchanged
      check(m_axis_tvalid && got === held, "R5", 64'(got), 64'(held));
    end
    rdy_now = pix_ready;
    allowed = rdy_now || rdy_prev;
    m_axis_tready = pick_tready();
    pix_valid = want && allowed;
    if (pix_valid) begin
      pix_data = d;
      {pix_line_first, pix_line_last, pix_frame_first, pix_frame_last} = f;
      if (!rdy_now) lag_n++;
    end else begin
      // noise on ignored cycles (R2)
      pix_data = {lfsr[7:0], lfsr, 16'h5A5A} >> 8;
      {pix_line_first, pix_line_last, pix_frame_first, pix_frame_last} = lfsr[3:0];
    end
    if (m_axis_tvalid && m_axis_tready) begin
      check(m_axis_tdata === exp_q[rd_n % 1024][DATA_W-1:0], "R2",
            64'(m_axis_tdata), 64'(exp_q[rd_n % 1024][DATA_W-1:0]));
      check(m_axis_tuser === exp_q[rd_n % 1024][DATA_W+1], "R3",
            64'(m_axis_tuser), 64'(exp_q[rd_n % 1024][DATA_W+1]));
      check(m_axis_tlast === exp_q[rd_n % 1024][DATA_W], "R4",
            64'(m_axis_tlast), 64'(exp_q[rd_n % 1024][DATA_W]));
      rd_n++;
    end
    if (pix_valid) begin
      exp_q[wr_n % 1024] = {f[1], f[2] | f[0], d};
      wr_n++;
    end
    hold_prev = m_axis_tvalid && !m_axis_tready;
    held = got;
    rdy_prev = rdy_now;
    sent = pix_valid;
  endtask

  task automatic send_frame(input int fid, input int w, input int h, input int gap,
                            output int cycles);
    bit sent;
    cycles = 0;
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < w; c++) begin
        logic [3:0] f;
        logic [DATA_W-1:0] d;
        d = {8'(fid), 8'(r), 8'(c)};
        // flag order: line_first, line_last, frame_first, frame_last
        f = {c == 0, c == w - 1, (r == 0) && (c == 0), (r == h - 1) && (c == w - 1)};
        sent = 0;
        while (!sent) begin
          step(1, d, f, sent);
          cycles++;
        end
      end
      for (int b = 0; b < 2 * gap; b++) step(0, '0, 4'h0, sent);
    end
  endtask

  task automatic drain();
    bit sent;
    int saved;
    saved = mode;
    mode = 0;
    for (int k = 0; k < 8; k++) step(0, '0, 4'h0, sent);
    mode = saved;
  endtask

  initial begin
    #(8ns * 200000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int fid;
    int cycles;
    fid = 0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(m_axis_tvalid === 1'b0, "R1", 64'(m_axis_tvalid), 64'd0);
    check(pix_ready === 1'b1, "R1", 64'(pix_ready), 64'd1);

    // R9: sustained rate with the sink always ready
    mode = 0;
    send_frame(fid, 4, 3, 0, cycles);
    fid++;
    check(cycles == 12, "R9", 64'(cycles), 64'd12);
    drain();

    for (int m = 0; m < 4; m++) begin
      mode = m;
      for (int w = 1; w <= 4; w++)
        for (int h = 1; h <= 3; h++)
          for (int g = 0; g <= 1; g++) begin
            send_frame(fid, w, h, g, cycles);
            fid++;
          end
      drain();
      check(wr_n == rd_n, "R2", 64'(rd_n), 64'(wr_n));
    end
    // R7: late pixels were taken and none were lost
    check(lag_n > 0, "R7", 64'(lag_n), 64'd1);
    check(wr_n == rd_n, "R7", 64'(rd_n), 64'(wr_n));

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule